// File: doc/BRIEF.md
# Control Register Mode Tracker

This block holds the processor's control-register mode state: the CR0 value, the CR4 value and the long-mode enable bit of EFER. It derives from them the hidden mode flags that the rest of the core reads each cycle. These flags are protected mode, add-segment, long mode active, 64-bit code segment, the three FPU trap controls and the FXSR-enable flag. It also produces the 32-bit A20 address mask and a single-cycle TLB flush request whenever paging-relevant state changes.

Software-visible writes arrive as one-cycle strobes with data. The A20 gate is a level input that the block compares against its own stored copy. Long mode has a two-state machine: `LM_LEGACY` and `LM_LONG`. The transition `enter` (LM_LEGACY to LM_LONG) fires on a CR0 write that raises PG while LME is set and CR4.PAE is set. The transition `leave` (LM_LONG to LM_LEGACY) fires on a CR0 write that clears PG. An entry attempt without PAE is an illegal transition. The block discards that write completely and leaves raising the exception to other logic.

All outputs update on the clock edge that samples the strobe and are visible in the following cycle. A concurrent write uses the EFER and CR4 values held before that edge.

Top module: `crm_mode_tracker`

## Requirements
- R1: After reset, CR0 reads 0x60000010, CR4 reads 0, LME is 0, the A20 mask is 0xFFFFFFFF, the flush output is 0, long mode and the 64-bit code flag are 0, protected mode is 0 and add-segment is 1.
- R2: A CR0 write that is applied stores the written data with bit 4 forced to 1.
- R3: An applied CR0 write that changes bit 31 (PG), bit 16 (WP) or bit 0 (PE) raises the flush output in the next cycle.
- R4: A CR0 write that takes bit 31 from 0 to 1 while LME is 1 enters long mode if CR4 bit 5 (PAE) is 1. If PAE is 0, the write is discarded: CR0, all flags and the flush output stay unchanged.
- R5: A CR0 write that takes bit 31 from 1 to 0 while long mode is active clears both long mode and the 64-bit code flag. A code-segment load sets the 64-bit code flag to the loaded L bit only while long mode is already active, otherwise to 0. An exit in the same cycle wins over a load.
- R6: The protected-mode flag equals CR0 bit 0, and add-segment is 1 exactly when that bit is 0.
- R7: The MP, EM and TS flags equal CR0 bits 1, 2 and 3.
- R8: A CR4 write stores the data with bit 9 (OSFXSR) cleared when `sse_present` is 0. The OSFXSR flag equals stored bit 9.
- R9: A CR4 write that changes bit 4 (PSE), bit 5 (PAE) or bit 7 (PGE) raises the flush output in the next cycle.
- R10: When `a20_gate` differs from the stored gate, the mask becomes 0xFFEFFFFF with bit 20 equal to the new gate value, and the flush output is raised. An unchanged gate alters neither.
- R11: The flush output is high for one cycle per clock edge that sees a trigger, even when CR0, CR4 and A20 triggers coincide. It is low after any edge without a trigger.
- R12: An EFER write stores `efer_lme_in` as LME at any time. Without a write, LME holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr0_wr_en | input | 1 | CR0 write strobe |
| cr0_wr_data | input | 32 | CR0 write data |
| cr4_wr_en | input | 1 | CR4 write strobe |
| cr4_wr_data | input | 32 | CR4 write data |
| efer_wr_en | input | 1 | EFER write strobe |
| efer_lme_in | input | 1 | Long-mode enable value to store |
| cs_load_en | input | 1 | Code-segment load strobe |
| cs_long_in | input | 1 | L bit of the loaded code segment |
| sse_present | input | 1 | Static: SSE support configured |
| a20_gate | input | 1 | A20 gate level |
| cr0_o | output | 32 | Stored CR0 |
| cr4_o | output | 32 | Stored CR4 |
| efer_lme_o | output | 1 | Stored LME |
| flag_pe | output | 1 | Protected mode flag |
| flag_addseg | output | 1 | Add-segment flag |
| flag_lma | output | 1 | Long mode active |
| flag_cs64 | output | 1 | 64-bit code segment |
| flag_mp | output | 1 | FPU monitor flag |
| flag_em | output | 1 | FPU emulate flag |
| flag_ts | output | 1 | Task-switched flag |
| flag_osfxsr | output | 1 | FXSR enable flag |
| a20_mask_o | output | 32 | Address mask for A20 |
| tlb_flush_o | output | 1 | One-cycle TLB flush request |

## Verification
Two functions can fall in the same cycle: an A20 toggle and a CR0 or CR4 write. Each raises a flush on its own, and the bench checks that together they give one pulse that drops after the next idle edge. The second collision is a long-mode exit coinciding with a code-segment load; exit must win, so the 64-bit flag ends at 0. Directed steps provoke both collisions. Random traffic with biased toggles of the watched bits repeats them, and a bench-side model of the requirements judges every output each cycle.

// File: rtl/crm_pkg.sv
package crm_pkg;
    localparam int CR_W    = 32;
    localparam int ADDR_W  = 32;
    localparam int A20_POS = 20;

    // CR0 bit positions decoded by this block
    localparam int B_PE = 0;
    localparam int B_MP = 1;
    localparam int B_EM = 2;
    localparam int B_TS = 3;
    localparam int B_ET = 4;
    localparam int B_WP = 16;
    localparam int B_PG = 31;

    // CR4 bit positions decoded by this block
    localparam int B_PSE    = 4;
    localparam int B_PAE    = 5;
    localparam int B_PGE    = 7;
    localparam int B_OSFXSR = 9;

    localparam logic [31:0] CR0_RESET = 32'h6000_0010;

    typedef enum logic {
        LM_LEGACY = 1'b0,
        LM_LONG   = 1'b1
    } lm_state_e;
endpackage

// File: rtl/crm_cr0_path.sv
module crm_cr0_path
    import crm_pkg::*;
#(
    parameter int W = CR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         lme,
    input  logic         pae,
    input  logic         cs_load,
    input  logic         cs_long,
    output logic [W-1:0] cr0_q,
    output logic         lma,
    output logic         cs64,
    output logic         pe_f,
    output logic         addseg_f,
    output logic         mp_f,
    output logic         em_f,
    output logic         ts_f,
    output logic         flush_hit
);
    localparam logic [W-1:0] WATCH   = (W'(1) << B_PG) | (W'(1) << B_WP) | (W'(1) << B_PE);
    localparam logic [W-1:0] ET_SET  = W'(1) << B_ET;
    localparam logic [W-1:0] RST_VAL = W'(CR0_RESET);

    lm_state_e    state_q, state_d;
    logic         pg_rise, pg_fall, enter_req, reject, apply, leave;
    logic [W-1:0] new_val;

    always_comb begin
        new_val   = wr_data | ET_SET;
        pg_rise   = wr_en & ~cr0_q[B_PG] & wr_data[B_PG];
        pg_fall   = wr_en & cr0_q[B_PG] & ~wr_data[B_PG];
        enter_req = pg_rise & lme;
        reject    = enter_req & ~pae;
        apply     = wr_en & ~reject;
        leave     = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            LM_LEGACY: if (enter_req && pae) state_d = LM_LONG;
            LM_LONG: begin
                if (pg_fall) begin
                    state_d = LM_LEGACY;
                    leave   = 1'b1;
                end
            end
        endcase
        flush_hit = apply & (|((new_val ^ cr0_q) & WATCH));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LM_LEGACY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr0_q    <= RST_VAL;
            pe_f     <= RST_VAL[B_PE];
            addseg_f <= ~RST_VAL[B_PE];
            mp_f     <= RST_VAL[B_MP];
            em_f     <= RST_VAL[B_EM];
            ts_f     <= RST_VAL[B_TS];
            cs64     <= 1'b0;
        end else begin
            if (apply) begin
                cr0_q    <= new_val;
                pe_f     <= wr_data[B_PE];
                addseg_f <= ~wr_data[B_PE];
                mp_f     <= wr_data[B_MP];
                em_f     <= wr_data[B_EM];
                ts_f     <= wr_data[B_TS];
            end
            if (leave)        cs64 <= 1'b0;
            else if (cs_load) cs64 <= cs_long & (state_q == LM_LONG);
        end
    end

    assign lma = (state_q == LM_LONG);

    // R2
    et_forced_chk: assert property (@(posedge clk) disable iff (!rst_n) cr0_q[B_ET]);
    // R4
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cr0_q[B_PG] && wr_data[B_PG] && lme && !pae) |=> ($stable(cr0_q) && !lma));
    // R4
    lma_needs_pg_chk: assert property (@(posedge clk) disable iff (!rst_n) lma |-> cr0_q[B_PG]);
    // R5
    cs64_needs_lma_chk: assert property (@(posedge clk) disable iff (!rst_n) cs64 |-> lma);
    // R6
    addseg_real_chk: assert property (@(posedge clk) disable iff (!rst_n) !pe_f |-> addseg_f);
    // R6
    pe_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n) pe_f == cr0_q[B_PE]);
    // R7
    fpu_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {mp_f, em_f, ts_f} == {cr0_q[B_MP], cr0_q[B_EM], cr0_q[B_TS]});
endmodule

// File: rtl/crm_cr4_path.sv
module crm_cr4_path
    import crm_pkg::*;
#(
    parameter int W = CR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         sse_ok,
    output logic [W-1:0] cr4_q,
    output logic         osfxsr_f,
    output logic         flush_hit
);
    localparam logic [W-1:0] WATCH = (W'(1) << B_PGE) | (W'(1) << B_PAE) | (W'(1) << B_PSE);
    localparam logic [W-1:0] OSX   = W'(1) << B_OSFXSR;

    logic [W-1:0] new_val;

    always_comb begin
        new_val   = sse_ok ? wr_data : (wr_data & ~OSX);
        flush_hit = wr_en & (|((new_val ^ cr4_q) & WATCH));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr4_q    <= '0;
            osfxsr_f <= 1'b0;
        end else if (wr_en) begin
            cr4_q    <= new_val;
            osfxsr_f <= new_val[B_OSFXSR];
        end
    end

    // R8
    no_sse_osfxsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sse_ok) |=> !cr4_q[B_OSFXSR]);
    // R8
    osfxsr_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osfxsr_f == cr4_q[B_OSFXSR]);
endmodule

// File: rtl/crm_a20_gate.sv
module crm_a20_gate #(
    parameter int AW       = 32,
    parameter int GATE_BIT = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_in,
    output logic [AW-1:0] mask_q,
    output logic          gate_q,
    output logic          flush_hit
);
    localparam logic [AW-1:0] GATE_ONE = AW'(1) << GATE_BIT;

    assign flush_hit = gate_in ^ gate_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b1;
            mask_q <= '1;
        end else if (flush_hit) begin
            gate_q <= gate_in;
            mask_q <= ~GATE_ONE | (gate_in ? GATE_ONE : '0);
        end
    end

    // R10
    mask_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &(mask_q | GATE_ONE));
    // R10
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[GATE_BIT] == gate_q);
endmodule

// File: rtl/crm_mode_tracker.sv
module crm_mode_tracker
    import crm_pkg::*;
#(
    parameter int W        = CR_W,
    parameter int AW       = ADDR_W,
    parameter int GATE_BIT = A20_POS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cr0_wr_en,
    input  logic [W-1:0]  cr0_wr_data,
    input  logic          cr4_wr_en,
    input  logic [W-1:0]  cr4_wr_data,
    input  logic          efer_wr_en,
    input  logic          efer_lme_in,
    input  logic          cs_load_en,
    input  logic          cs_long_in,
    input  logic          sse_present,
    input  logic          a20_gate,
    output logic [W-1:0]  cr0_o,
    output logic [W-1:0]  cr4_o,
    output logic          efer_lme_o,
    output logic          flag_pe,
    output logic          flag_addseg,
    output logic          flag_lma,
    output logic          flag_cs64,
    output logic          flag_mp,
    output logic          flag_em,
    output logic          flag_ts,
    output logic          flag_osfxsr,
    output logic [AW-1:0] a20_mask_o,
    output logic          tlb_flush_o
);
    logic cr0_hit, cr4_hit, a20_hit, gate_q;

    crm_cr0_path #(.W(W)) u_cr0 (
        .clk(clk), .rst_n(rst_n), .wr_en(cr0_wr_en), .wr_data(cr0_wr_data),
        .lme(efer_lme_o), .pae(cr4_o[B_PAE]), .cs_load(cs_load_en), .cs_long(cs_long_in),
        .cr0_q(cr0_o), .lma(flag_lma), .cs64(flag_cs64), .pe_f(flag_pe),
        .addseg_f(flag_addseg), .mp_f(flag_mp), .em_f(flag_em), .ts_f(flag_ts),
        .flush_hit(cr0_hit)
    );

    crm_cr4_path #(.W(W)) u_cr4 (
        .clk(clk), .rst_n(rst_n), .wr_en(cr4_wr_en), .wr_data(cr4_wr_data),
        .sse_ok(sse_present), .cr4_q(cr4_o), .osfxsr_f(flag_osfxsr), .flush_hit(cr4_hit)
    );

    crm_a20_gate #(.AW(AW), .GATE_BIT(GATE_BIT)) u_a20 (
        .clk(clk), .rst_n(rst_n), .gate_in(a20_gate), .mask_q(a20_mask_o),
        .gate_q(gate_q), .flush_hit(a20_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            efer_lme_o  <= 1'b0;
            tlb_flush_o <= 1'b0;
        end else begin
            if (efer_wr_en) efer_lme_o <= efer_lme_in;
            tlb_flush_o <= cr0_hit | cr4_hit | a20_hit;
        end
    end

    // R11
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_o |-> $past(cr0_wr_en || cr4_wr_en || (a20_gate != gate_q)));
    // R12
    lme_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !efer_wr_en |=> $stable(efer_lme_o));
endmodule

// File: tb/crm_mode_tracker_bench.sv
`timescale 1ns/1ps
module crm_mode_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cr0_wr_en = 1'b0, cr4_wr_en = 1'b0, efer_wr_en = 1'b0;
    logic [31:0] cr0_wr_data = '0, cr4_wr_data = '0;
    logic        efer_lme_in = 1'b0, cs_load_en = 1'b0, cs_long_in = 1'b0;
    logic        sse_present = 1'b1, a20_gate = 1'b1;
    logic [31:0] cr0_o, cr4_o, a20_mask_o;
    logic        efer_lme_o, flag_pe, flag_addseg, flag_lma, flag_cs64;
    logic        flag_mp, flag_em, flag_ts, flag_osfxsr, tlb_flush_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model of the requirements
    logic [31:0] m_cr0 = 32'h6000_0010, m_cr4 = '0, m_mask = 32'hFFFF_FFFF;
    logic        m_lme = 0, m_lma = 0, m_cs64 = 0, m_gate = 1, m_flush = 0;

    always #5 clk = ~clk;

    crm_mode_tracker u_crm_mode_tracker (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 cr0", cr0_o, m_cr0);
        chk("R4 lma", {31'd0, flag_lma}, {31'd0, m_lma});
        chk("R5 cs64", {31'd0, flag_cs64}, {31'd0, m_cs64});
        chk("R6 pe/addseg", {30'd0, flag_pe, flag_addseg}, {30'd0, m_cr0[0], ~m_cr0[0]});
        chk("R7 mp/em/ts", {29'd0, flag_mp, flag_em, flag_ts}, {29'd0, m_cr0[1], m_cr0[2], m_cr0[3]});
        chk("R8 cr4", cr4_o, m_cr4);
        chk("R8 osfxsr", {31'd0, flag_osfxsr}, {31'd0, m_cr4[9]});
        chk("R10 a20 mask", a20_mask_o, m_mask);
        chk("R3 R9 R10 R11 flush", {31'd0, tlb_flush_o}, {31'd0, m_flush});
        chk("R12 lme", {31'd0, efer_lme_o}, {31'd0, m_lme});
    endtask

    task automatic step(input logic c0w, input logic [31:0] c0d, input logic c4w,
                        input logic [31:0] c4d, input logic ew, input logic ed,
                        input logic csl, input logic csv, input logic g);
        logic enter, rej, leave, app;
        logic [31:0] n0, n4;
        enter = c0w && !m_cr0[31] && c0d[31] && m_lme;
        rej   = enter && !m_cr4[5];
        leave = c0w && m_cr0[31] && !c0d[31] && m_lma;
        app   = c0w && !rej;
        n0    = app ? (c0d | 32'h0000_0010) : m_cr0;
        n4    = c4w ? (sse_present ? c4d : (c4d & ~32'h0000_0200)) : m_cr4;
        cr0_wr_en = c0w; cr0_wr_data = c0d; cr4_wr_en = c4w; cr4_wr_data = c4d;
        efer_wr_en = ew; efer_lme_in = ed; cs_load_en = csl; cs_long_in = csv; a20_gate = g;
        @(posedge clk);
        m_flush = (app && ((n0 ^ m_cr0) & 32'h8001_0001) != 0) ||
                  (c4w && ((n4 ^ m_cr4) & 32'h0000_00B0) != 0) || (g != m_gate);
        m_cs64  = leave ? 1'b0 : (csl ? (csv && m_lma) : m_cs64);
        m_lma   = (enter && !rej) ? 1'b1 : (leave ? 1'b0 : m_lma);
        m_cr0   = n0;
        m_cr4   = n4;
        m_lme   = ew ? ed : m_lme;
        m_gate  = g;
        m_mask  = g ? 32'hFFFF_FFFF : 32'hFFEF_FFFF;
        @(negedge clk);
        cr0_wr_en = 0; cr4_wr_en = 0; efer_wr_en = 0; cs_load_en = 0;
        compare_all();
    endtask

    task automatic idle();
        step(0, '0, 0, '0, 0, 0, 0, 0, m_gate);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk("R1 cr0 reset", cr0_o, 32'h6000_0010);
        chk("R1 cr4 reset", cr4_o, 32'h0);
        chk("R1 mask reset", a20_mask_o, 32'hFFFF_FFFF);
        chk("R1 flags reset", {24'd0, flag_pe, flag_addseg, flag_lma, flag_cs64, efer_lme_o, tlb_flush_o, flag_osfxsr, flag_ts},
            {24'd0, 1'b0, 1'b1, 6'd0});
        idle();                                                    // R10 gate unchanged: no flush
        step(0, '0, 0, '0, 1, 1, 0, 0, 1);                         // R12 set LME
        step(1, 32'h8000_0011, 0, '0, 0, 0, 0, 0, 1);              // R4 rejected: PAE clear
        chk("R4 rejected write leaves cr0", cr0_o, 32'h6000_0010);
        step(0, '0, 1, 32'h0000_0020, 0, 0, 0, 0, 1);              // R9 PAE change flushes
        step(1, 32'h8000_0011, 0, '0, 0, 0, 0, 0, 1);              // R4 enter long mode
        chk("R4 long mode entered", {31'd0, flag_lma}, 32'd1);
        step(0, '0, 0, '0, 0, 0, 1, 1, 1);                         // R5 load 64-bit code
        chk("R5 cs64 set", {31'd0, flag_cs64}, 32'd1);
        step(1, 32'h0000_0001, 0, '0, 0, 0, 1, 1, 0);              // R5 R11 exit + load + A20
        chk("R5 exit wins over load", {30'd0, flag_lma, flag_cs64}, 32'd0);
        chk("R11 single pulse on collision", {31'd0, tlb_flush_o}, 32'd1);
        idle();
        chk("R11 pulse dropped", {31'd0, tlb_flush_o}, 32'd0);
        sse_present = 1'b0;
        step(0, '0, 1, 32'h0000_0220, 0, 0, 0, 0, 0);              // R8 no SSE
        chk("R8 osfxsr masked", cr4_o, 32'h0000_0020);
        sse_present = 1'b1;
        step(0, '0, 1, 32'h0000_0220, 0, 0, 0, 0, 0);
        chk("R8 osfxsr kept", cr4_o, 32'h0000_0220);
        step(0, '0, 0, '0, 0, 0, 0, 0, 1);                         // R10 gate back on

        for (int i = 0; i < 3000; i++) begin
            logic c0w, c4w, ew, csl, g;
            logic [31:0] c0d, c4d;
            if (i % 500 == 499) sse_present = ~sse_present;
            c0w = ($urandom % 3) == 0;
            c0d = m_cr0 ^ ($urandom & 32'h8001_000F) ^ (($urandom % 8 == 0) ? $urandom : 32'h0);
            c4w = ($urandom % 4) == 0;
            c4d = m_cr4 ^ ($urandom & 32'h0000_02B0);
            ew  = ($urandom % 16) == 0;
            csl = ($urandom % 4) == 0;
            g   = (($urandom % 8) == 0) ? ~m_gate : m_gate;
            step(c0w, c0d, c4w, c4d, ew, ($urandom % 4) != 0, csl, 1'($urandom), g);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule